// File: doc/BRIEF.md
# SDRAM Command Monitor with Per-Bank Row Tracking

This block watches the control pins of a synchronous DRAM bus and keeps a live picture of what the memory is doing. On every rising clock edge it samples chip select, the three strobes (RAS, CAS, WE), the clock-enable pin, the bank address and the address bus. It turns that sample into one command and decides whether the command is legal in the current bank state. It then updates, for each of four banks, an open/closed flag and the row number that the bank holds open.

Column commands start a data burst whose length comes from a static configuration input. Read beats are reported on a read-valid strobe after the configured CAS latency. Write beats are reported on a write strobe. Address bit 10 selects auto-precharge on a read or write, and all banks on a precharge. A refresh command moves an internal refresh address counter forward. An illegal command raises a one-cycle error pulse and leaves the bank state untouched. The monitor suits a memory-controller verification harness or a bus-protocol watchdog inside a larger chip.

All outputs are registered. Each output describes the clock edge that has just passed, and it is valid in the cycle that follows that edge.

Top module: `sdram_bank_monitor`

## Requirements
- R1: While `cs_n` is high, the other inputs are ignored. A selected command with RAS, CAS and WE all high (no-operation), or with the encodings {H,H,L} or {L,L,L}, changes no bank, burst or refresh state and raises no error.
- R2: An Activate (`cs_n`=0, RAS=0, CAS=1, WE=1) sent to an idle bank `ba` makes `bank_active[ba]`=1 and places `addr` on that bank's slice of `open_row`, both in the cycle after the edge. The slice of an idle bank reads zero.
- R3: An Activate sent to a bank that is already active sets `illegal_cmd` for one cycle and leaves the bank's flag and row unchanged.
- R4: A Read (RAS=1, CAS=0, WE=1) is sampled at edge k and sent to an active bank. `rd_valid` is then high in the cycles that follow edges k+CL-1 through k+CL+BL-2, and low in the cycles around them. CL is 3 when `cfg_cl3`=1 and 2 otherwise. BL is 1, 2, 4 or 8 for `cfg_bl` = 0, 1, 2 or 3.
- R5: A Write (RAS=1, CAS=0, WE=0) is sampled at edge k and sent to an active bank. `wr_strobe` is then high in the cycles that follow edges k through k+BL-1, for exactly BL cycles.
- R6: A Read or Write sent to an idle bank sets `illegal_cmd`, starts no burst and changes no bank.
- R7: A Read or Write with `addr[10]`=1 sampled at edge k makes its bank idle at edge k+BL. A command sampled at edge k+BL already sees that bank as idle: a Read or Write to it is an error, and an Activate to it is legal.
- R8: A Precharge (RAS=0, CAS=1, WE=0) makes bank `ba` idle, or every bank when `addr[10]`=1. It is never an error. It also ends any burst in progress: no read or write beat happens at the precharge edge or after it, although read beats already issued still appear on `rd_valid`.
- R9: A refresh (RAS=0, CAS=0, WE=1 with `cke`=1) while all banks are idle adds one to `ref_row`, which wraps from its maximum to zero. With `cke`=0 the same encoding is ignored.
- R10: A refresh while any bank is active sets `illegal_cmd` and leaves `ref_row` and the banks unchanged.
- R11: A legal Read or Write that arrives while an earlier burst still has beats left replaces that burst from its own edge on. The auto-precharge of the replaced burst is dropped, so its bank stays open.
- R12: While `rst_n` is low, every bank is idle, every `open_row` slice is zero, and `rd_valid`, `wr_strobe`, `illegal_cmd` and `ref_row` are zero. This holds even when reset arrives in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge samples commands |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| cke | input | 1 | Clock enable; must be high for a refresh to count |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row address; bit 10 is the precharge option |
| cfg_cl3 | input | 1 | CAS latency select: 1 = three cycles, 0 = two |
| cfg_bl | input | 2 | Burst length code: beats = 1 << cfg_bl |
| bank_active | output | 4 | One open flag per bank |
| open_row | output | 48 | Open row per bank, bank b in bits [12b+11:12b] |
| rd_valid | output | 1 | Read data valid on the bus at the next edge |
| wr_strobe | output | 1 | A write data word was taken at the last edge |
| illegal_cmd | output | 1 | One-cycle pulse for a command illegal in the current state |
| ref_row | output | 14 | Internal refresh address counter |

## Verification
The difficult case is the edge where a burst with auto-precharge finishes at the same moment as a new command arrives at the bank it is closing. The bench builds this deliberately: it sends a Read or Write with bit 10 set, waits BL-1 idle cycles, and then sends a Read, an Activate or a refresh exactly at the closing edge. It judges the result by whether an error pulse appears and which row becomes open afterwards. A second collision is a new burst or a precharge that lands while a burst still has beats left. Its check is the exact count of beats on the strobes and whether the old bank stays open. A behavioural model in the bench, built on a per-cycle schedule of expected read-valid beats, is compared with every output on every cycle.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  // Decoded bus operation after chip select and clock enable are applied.
  typedef enum logic [2:0] {
    OP_NOP,
    OP_ACT,
    OP_READ,
    OP_WRITE,
    OP_PRE,
    OP_REF,
    OP_IGN
  } op_e;

  // Beats in a burst for the two-bit length code.
  function automatic logic [3:0] bl_beats(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/sdt_decode.sv
module sdt_decode
  import sdt_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic cke,
  output op_e  op
);

  always_comb begin
    op = OP_IGN;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b111:  op = OP_NOP;
        3'b011:  op = OP_ACT;
        3'b101:  op = OP_READ;
        3'b100:  op = OP_WRITE;
        3'b010:  op = OP_PRE;
        3'b001:  op = cke ? OP_REF : OP_IGN;
        default: op = OP_IGN;
      endcase
    end
  end

endmodule

// File: rtl/sdt_bank.sv
module sdt_bank #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             active_o,
  output logic [ROW_W-1:0] row_o
);

  logic             active_q, active_d;
  logic [ROW_W-1:0] row_q;

  // Opening has priority: an auto-precharge closing and a reopen may share an edge.
  always_comb begin
    active_d = active_q;
    if (open_i)       active_d = 1'b1;
    else if (close_i) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      row_q    <= '0;
    end else begin
      active_q <= active_d;
      if (open_i) row_q <= row_i;
    end
  end

  assign active_o = active_q;
  assign row_o    = row_q;

  // R2
  open_only_on_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> $past(open_i));

  // R3
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q) && !$past(open_i)) |-> $stable(row_q));

endmodule

// File: rtl/sdt_burst.sv
module sdt_burst
  import sdt_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            start_wr_i,
  input  logic            start_ap_i,
  input  logic [BA_W-1:0] start_ba_i,
  input  logic            stop_i,
  input  logic [1:0]      cfg_bl,
  input  logic            cfg_cl3,
  output logic [NB-1:0]   ap_close_o,
  output logic            rd_valid_o,
  output logic            wr_strobe_o
);

  localparam int CNT_W   = 3;
  localparam int LAT_MAX = 3;

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               wr_q, wr_d, ap_q, ap_d;
  logic [BA_W-1:0]    ba_q, ba_d;
  logic [LAT_MAX-1:0] pipe_q;
  logic               wrs_q;
  logic [3:0]         beats;
  logic               cont, beat_rd, beat_wr, finishing;

  assign beats = bl_beats(cfg_bl);

  always_comb begin
    cont      = busy_q && (cnt_q != '0) && !stop_i && !start_i;
    beat_rd   = (start_i && !start_wr_i) || (cont && !wr_q);
    beat_wr   = (start_i &&  start_wr_i) || (cont &&  wr_q);
    finishing = busy_q && (cnt_q == '0);
    for (int b = 0; b < NB; b++)
      ap_close_o[b] = finishing && ap_q && (ba_q == BA_W'(b));
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    ap_d   = ap_q;
    ba_d   = ba_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(beats - 4'd1);
      wr_d   = start_wr_i;
      ap_d   = start_ap_i;
      ba_d   = start_ba_i;
    end else if (stop_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      ap_q   <= 1'b0;
      ba_q   <= '0;
      pipe_q <= '0;
      wrs_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      ap_q   <= ap_d;
      ba_q   <= ba_d;
      pipe_q <= {pipe_q[LAT_MAX-2:0], beat_rd};
      wrs_q  <= beat_wr;
    end
  end

  assign rd_valid_o  = cfg_cl3 ? pipe_q[2] : pipe_q[1];
  assign wr_strobe_o = wrs_q;

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ({1'b0, cnt_q} < beats));

  // R8
  pre_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_i) |-> !wr_strobe_o);

endmodule

// File: rtl/sdram_bank_monitor.sv
module sdram_bank_monitor
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 12,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int REF_W    = BA_W + ROW_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic                       cke,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic                       cfg_cl3,
  input  logic [1:0]                 cfg_bl,
  output logic [NUM_BANKS-1:0]       bank_active,
  output logic [NUM_BANKS*ROW_W-1:0] open_row,
  output logic                       rd_valid,
  output logic                       wr_strobe,
  output logic                       illegal_cmd,
  output logic [REF_W-1:0]           ref_row
);

  op_e                  op;
  logic [NUM_BANKS-1:0] active, ap_close, eff_active, open_v, pre_hit, close_v;
  logic [ROW_W-1:0]     row_w [NUM_BANKS];
  logic                 err_d, rw_ok, ref_ok;
  logic                 err_q;
  logic [REF_W-1:0]     ref_q;

  sdt_decode u_decode (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cke   (cke),
    .op    (op)
  );

  // A bank whose auto-precharge lands on this edge already counts as idle.
  assign eff_active = active & ~ap_close;

  always_comb begin
    err_d   = 1'b0;
    rw_ok   = 1'b0;
    ref_ok  = 1'b0;
    open_v  = '0;
    pre_hit = '0;
    case (op)
      OP_ACT: begin
        if (eff_active[ba]) err_d      = 1'b1;
        else                open_v[ba] = 1'b1;
      end
      OP_READ, OP_WRITE: begin
        if (!eff_active[ba]) err_d = 1'b1;
        else                 rw_ok = 1'b1;
      end
      OP_PRE: begin
        if (addr[AP_BIT]) pre_hit     = '1;
        else              pre_hit[ba] = 1'b1;
      end
      OP_REF: begin
        if (|eff_active) err_d  = 1'b1;
        else             ref_ok = 1'b1;
      end
      default: ;
    endcase
    close_v = ap_close | pre_hit;
  end

  sdt_burst #(.NB(NUM_BANKS), .BA_W(BA_W)) u_burst (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (rw_ok),
    .start_wr_i  (op == OP_WRITE),
    .start_ap_i  (addr[AP_BIT]),
    .start_ba_i  (ba),
    .stop_i      (op == OP_PRE),
    .cfg_bl      (cfg_bl),
    .cfg_cl3     (cfg_cl3),
    .ap_close_o  (ap_close),
    .rd_valid_o  (rd_valid),
    .wr_strobe_o (wr_strobe)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdt_bank #(.ROW_W(ROW_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_i   (open_v[b]),
      .close_i  (close_v[b]),
      .row_i    (addr),
      .active_o (active[b]),
      .row_o    (row_w[b])
    );
    assign open_row[b*ROW_W +: ROW_W] = active[b] ? row_w[b] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ref_q <= '0;
    end else begin
      err_q <= err_d;
      if (ref_ok) ref_q <= ref_q + REF_W'(1);
    end
  end

  assign bank_active = active;
  assign illegal_cmd = err_q;
  assign ref_row     = ref_q;

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> !$past(cs_n));

  // R10
  ref_hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_cmd |-> $stable(ref_row));

  // R9
  ref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_row != $past(ref_row)) |-> (bank_active == '0));

endmodule

// File: tb/sdram_bank_monitor_test.sv
`timescale 1ns/1ps
module sdram_bank_monitor_test;

  localparam int NB    = 4;
  localparam int ROW_W = 12;
  localparam int REF_M = 1 << 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [ROW_W-1:0] addr = '0;
  logic cfg_cl3 = 1'b0;
  logic [1:0] cfg_bl = 2'd2;
  logic [NB-1:0] bank_active;
  logic [NB*ROW_W-1:0] open_row;
  logic rd_valid, wr_strobe, illegal_cmd;
  logic [13:0] ref_row;

  sdram_bank_monitor uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .cfg_cl3(cfg_cl3),
    .cfg_bl(cfg_bl), .bank_active(bank_active), .open_row(open_row),
    .rd_valid(rd_valid), .wr_strobe(wr_strobe), .illegal_cmd(illegal_cmd),
    .ref_row(ref_row)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  string cur_req = "R12";
  bit checking = 0, done = 0;

  // Behavioural reference state.
  bit m_act [NB];
  int m_row [NB];
  bit m_busy, m_wr, m_ap, m_wrs, m_err;
  int m_cnt, m_ba, m_ref;
  bit exp_rv [int];

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_act[b] = 0; m_row[b] = 0; end
    m_busy = 0; m_wr = 0; m_ap = 0; m_wrs = 0; m_err = 0;
    m_cnt = 0; m_ba = 0; m_ref = 0;
    exp_rv.delete();
  endtask

  task automatic model_step();
    int bl, cl, b_i;
    bit fin_ap, rdb, wrb, err, start, any;
    bit eff [NB];
    bit sel, is_act, is_rd, is_wr, is_pre, is_ref;
    bl = 1 << cfg_bl;
    cl = cfg_cl3 ? 3 : 2;
    b_i = int'(ba);
    fin_ap = m_busy && m_cnt == 0 && m_ap;
    any = 0;
    for (int b = 0; b < NB; b++) begin
      eff[b] = m_act[b] && !(fin_ap && b == m_ba);
      any |= eff[b];
    end
    sel    = !cs_n;
    is_act = sel && !ras_n &&  cas_n &&  we_n;
    is_rd  = sel &&  ras_n && !cas_n &&  we_n;
    is_wr  = sel &&  ras_n && !cas_n && !we_n;
    is_pre = sel && !ras_n &&  cas_n && !we_n;
    is_ref = sel && !ras_n && !cas_n &&  we_n && cke;
    rdb = 0; wrb = 0; err = 0; start = 0;
    if (fin_ap) m_act[m_ba] = 0;
    if (is_act) begin
      if (eff[b_i]) err = 1;
      else begin m_act[b_i] = 1; m_row[b_i] = int'(addr); end
    end
    if (is_rd || is_wr) begin
      if (!eff[b_i]) err = 1; else start = 1;
    end
    if (is_pre) begin
      if (addr[10]) for (int b = 0; b < NB; b++) m_act[b] = 0;
      else m_act[b_i] = 0;
    end
    if (is_ref) begin
      if (any) err = 1; else m_ref = (m_ref + 1) % REF_M;
    end
    if (start) begin
      if (is_rd) rdb = 1; else wrb = 1;
      m_busy = 1; m_cnt = bl - 1; m_wr = is_wr; m_ap = addr[10]; m_ba = b_i;
    end else if (is_pre) begin
      m_busy = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 0) m_busy = 0;
      else begin
        if (m_wr) wrb = 1; else rdb = 1;
        m_cnt--;
      end
    end
    if (rdb) exp_rv[cyc + cl - 1] = 1;
    m_wrs = wrb;
    m_err = err;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else model_step();
  end

  // Compare every output against the model in the middle of each cycle.
  always @(negedge clk) begin
    if (rst_n && checking && !done) begin
      for (int b = 0; b < NB; b++) begin
        chk(cur_req, $sformatf("bank_active[%0d]", b), int'(bank_active[b]), int'(m_act[b]));
        chk(cur_req, $sformatf("open_row[%0d]", b), int'(open_row[b*ROW_W +: ROW_W]),
            m_act[b] ? m_row[b] : 0);
      end
      chk(cur_req, "rd_valid", int'(rd_valid), int'(exp_rv.exists(cyc)));
      chk(cur_req, "wr_strobe", int'(wr_strobe), int'(m_wrs));
      chk(cur_req, "illegal_cmd", int'(illegal_cmd), int'(m_err));
      chk(cur_req, "ref_row", int'(ref_row), m_ref);
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic drive(bit c, bit r, bit ca, bit w, bit k, int b, int a);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k;
    ba = 2'(b); addr = ROW_W'(a);
  endtask

  task automatic nop(int n);
    for (int i = 0; i < n; i++) drive(0, 1, 1, 1, 1, 0, 0);
  endtask
  task automatic act(int b, int row);  drive(0, 0, 1, 1, 1, b, row); endtask
  task automatic rd(int b, bit ap);    drive(0, 1, 0, 1, 1, b, ap ? 'h400 : 0); endtask
  task automatic wr(int b, bit ap);    drive(0, 1, 0, 0, 1, b, ap ? 'h400 : 0); endtask
  task automatic pre(int b, bit all);  drive(0, 0, 1, 0, 1, b, all ? 'h400 : 0); endtask
  task automatic refc(bit k);          drive(0, 0, 0, 1, k, 0, 0); endtask

  task automatic reset_probe();
    chk("R12", "bank_active", int'(bank_active), 0);
    chk("R12", "open_row", int'(open_row != '0), 0);
    chk("R12", "rd_valid", int'(rd_valid), 0);
    chk("R12", "wr_strobe", int'(wr_strobe), 0);
    chk("R12", "illegal_cmd", int'(illegal_cmd), 0);
    chk("R12", "ref_row", int'(ref_row), 0);
  endtask

  initial begin
    int ref0;
    cur_req = "R12";
    repeat (3) @(negedge clk);
    reset_probe();
    rst_n = 1'b1;
    checking = 1;
    nop(2);

    cur_req = "R2";  act(0, 'h123); act(1, 'h0AB); nop(2);
    cur_req = "R3";  act(0, 'h055); nop(2);
    cur_req = "R6";  rd(2, 0); wr(3, 0); nop(2);
    cur_req = "R5";  wr(0, 0); nop(6);
    cur_req = "R4";  rd(1, 0); nop(8);
    cfg_bl = 2'd3; cfg_cl3 = 1'b1;
    rd(0, 0); nop(12);
    cfg_bl = 2'd0; cfg_cl3 = 1'b0;
    rd(1, 0); nop(4);
    cfg_bl = 2'd1;
    rd(1, 0); wr(0, 0); nop(5);

    cfg_bl = 2'd3; cfg_cl3 = 1'b1;
    cur_req = "R8";  rd(0, 0); nop(2); pre(2, 0); nop(6);
    wr(1, 0); nop(1); pre(1, 0); nop(3);
    act(1, 'h077); nop(4);

    cfg_bl = 2'd2; cfg_cl3 = 1'b0;
    cur_req = "R7";  rd(0, 1); nop(3); rd(0, 0); nop(4);
    act(0, 'h200); wr(0, 1); nop(3); act(0, 'h201); nop(3);

    cur_req = "R11"; rd(0, 0); nop(1); rd(1, 0); nop(6);
    wr(1, 1); nop(1); wr(0, 0); nop(6);
    chk("R11", "bank1 kept open", int'(bank_active[1]), 1);

    cur_req = "R8";  pre(0, 1); nop(2);
    chk("R8", "all banks idle", int'(bank_active), 0);

    cur_req = "R1";  act(2, 'h003);
    drive(1, 0, 1, 1, 1, 2, 'h111);
    drive(1, 1, 0, 1, 1, 3, 0);
    drive(1, 0, 0, 1, 1, 0, 0);
    drive(0, 1, 1, 0, 1, 2, 'h400);
    drive(0, 0, 0, 0, 1, 2, 'h7FF);
    nop(3);
    chk("R1", "bank2 row", int'(open_row[2*ROW_W +: ROW_W]), 'h003);
    pre(0, 1); nop(1);

    cur_req = "R10"; act(2, 'h044); rd(2, 1); nop(3); refc(1); nop(3);
    act(3, 'h009); refc(1); nop(2); pre(3, 0); nop(1);

    cur_req = "R9";  refc(0); nop(1);
    ref0 = int'(ref_row);
    for (int i = 0; i < REF_M; i++) refc(1);
    nop(2);
    chk("R9", "ref_row after full wrap", int'(ref_row), ref0);

    cur_req = "R12"; cfg_bl = 2'd3; act(0, 'h321); rd(0, 0); nop(1);
    #1 rst_n = 1'b0;
    @(negedge clk);
    reset_probe();
    rst_n = 1'b1;
    nop(12);
    summary();
  end

endmodule